// File: doc/BRIEF.md
# Programmable Watchdog Timer with Output Steering

This block supervises a host processor from inside a timekeeping peripheral. Software programs one 8-bit control register. That register sets a time-out as a 5-bit multiplier times a coded unit period. Time is measured from a one-cycle 16 Hz tick-enable input. The host must touch the register before the period runs out.

If the period runs out, the steering bit picks the response:
- **Steering bit 0:** a latched flag is set and the shared active-low interrupt pin is pulled low.
- **Steering bit 1:** a fixed-length active-low reset pulse is produced, and the register disables itself.

The shared pin also carries a frequency-test square wave when that function is on. The watchdog wins the pin when it is armed toward it.

The bus is a plain strobe interface with no handshake. `sel_wd` or `sel_st` picks a register, and `rd_en` or `wr_en` marks a one-cycle access sampled at the rising clock edge. Read data is combinational while a select is high. There is no streaming path, so no valid/ready pair applies.

Top module: `wdog_supervisor`

## Requirements
- R1: The control register holds the steering bit at bit 7, an unsigned multiplier at bits 6:2 and a resolution code at bits 1:0. A read with `sel_wd` returns the last value written.
- R2: The time-out equals the multiplier times 1, 4, 16 or 64 ticks for resolution codes 00, 01, 10 and 11. The expiry happens on the tick that completes the count. With steering bit 0 the count then starts again.
- R3: Any read or write with `sel_wd` restarts the count from zero.
- R4: A multiplier of 0 disables the watchdog whatever the other bits hold: no flag and no reset pulse are produced.
- R5: On expiry with steering bit 0, the flag is set and `irq_ft_n` goes low in the cycle after the expiring tick edge. Both stay asserted until the status register is read or the control register is read or written.
- R6: A read with `sel_st` returns the flag in bit 7 and the frequency-test enable in bit 0, with 0 in the other bits.
  - That read clears the flag, unless an expiry sets it in the same cycle.
  - A write with `sel_st` loads the frequency-test enable from data bit 0 and leaves the flag unchanged.
- R7: On expiry with steering bit 1, `rst_out_n` goes low after the expiring tick edge. It returns high on the second tick after that edge. The flag is not set.
- R8: An expiry with steering bit 1 clears the control register and the frequency-test enable to 0.
- R9: `irq_ft_n` is driven as follows:
  - It is low while the flag is set.
  - Otherwise it follows `ft_wave` when the frequency-test enable is 1 and the watchdog is not armed with steering bit 0.
  - Otherwise it is high.
- R10: After reset, the control register, the flag and the frequency-test enable are 0, and both outputs are high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | One-cycle 16 Hz time-base enable |
| sel_wd | input | 1 | Selects the control register |
| sel_st | input | 1 | Selects the status register |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register |
| ft_wave | input | 1 | Frequency-test square wave |
| irq_ft_n | output | 1 | Shared active-low interrupt / frequency-test pin |
| rst_out_n | output | 1 | Active-low reset pulse |

## Verification
A table of control values is tried, one for each resolution code and for small and maximum multipliers. Counting the ticks to the first interrupt separates a wrong unit scale from a wrong multiply, and catches an off-by-one terminal count.

Directed patterns cover the remaining behaviour:
- A multiplier-0 value with the steering bit set shows that the other bits cannot arm the block.
- A control read in mid-count shows the restart.
- A steered time-out shows the pulse length and the self-clear.
- Toggling `ft_wave` with the watchdog armed and disarmed shows which source owns the shared pin.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int MULT_W = 5;
  localparam int RES_W  = 2;
  localparam int UNIT_SHIFT_MAX = 2 * ((1 << RES_W) - 1);
  localparam int CNT_W  = MULT_W + UNIT_SHIFT_MAX;

  typedef struct packed {
    logic              steer;
    logic [MULT_W-1:0] mult;
    logic [RES_W-1:0]  res;
  } wd_cfg_t;

  // ticks per unit = 4**res
  function automatic logic [CNT_W-1:0] terminal(input logic [MULT_W-1:0] m,
                                                input logic [RES_W-1:0] r);
    return CNT_W'(m) << {r, 1'b0};
  endfunction
endpackage

// File: rtl/wdog_counter.sv
module wdog_counter
  import wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              restart,
  input  logic [MULT_W-1:0] mult,
  input  logic [RES_W-1:0]  res,
  output logic              expire,
  output logic [CNT_W-1:0]  cnt
);
  logic             armed;
  logic [CNT_W-1:0] term;

  assign armed  = (mult != '0);
  assign term   = terminal(mult, res);
  assign expire = tick && armed && !restart && (cnt == term - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (restart || !armed) cnt <= '0;
    else if (expire)            cnt <= '0;
    else if (tick)              cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
  parameter int PULSE_TICKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic start,
  output logic active
);
  localparam int PW = (PULSE_TICKS > 1) ? $clog2(PULSE_TICKS) : 1;
  logic [PW-1:0] pcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      pcnt   <= '0;
    end else if (start) begin
      active <= 1'b1;
      pcnt   <= '0;
    end else if (active && tick) begin
      if (pcnt == PW'(PULSE_TICKS - 1)) active <= 1'b0;
      else                              pcnt   <= pcnt + 1'b1;
    end
  end
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel_wd,
  input  logic       sel_st,
  input  logic       rd_en,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  input  logic       expire,
  output wd_cfg_t    cfg,
  output logic       flag,
  output logic       ft_on,
  output logic [7:0] rdata
);
  logic wd_wr, st_rd, st_wr, wd_acc, dog_irq, dog_rst;

  assign wd_wr   = sel_wd && wr_en;
  assign wd_acc  = sel_wd && (rd_en || wr_en);
  assign st_rd   = sel_st && rd_en;
  assign st_wr   = sel_st && wr_en;
  assign dog_irq = expire && !cfg.steer;
  assign dog_rst = expire &&  cfg.steer;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cfg <= '0;
    else if (dog_rst) cfg <= '0;
    else if (wd_wr)   cfg <= wd_cfg_t'(wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 flag <= 1'b0;
    else if (dog_irq)           flag <= 1'b1;
    else if (st_rd || wd_acc)   flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ft_on <= 1'b0;
    else if (dog_rst) ft_on <= 1'b0;
    else if (st_wr)   ft_on <= wdata[0];
  end

  always_comb begin
    if (sel_wd)      rdata = cfg;
    else if (sel_st) rdata = {flag, 6'b0, ft_on};
    else             rdata = '0;
  end
endmodule

// File: rtl/wdog_supervisor.sv
module wdog_supervisor
  import wdog_pkg::*;
#(
  parameter int PULSE_TICKS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic       sel_wd,
  input  logic       sel_st,
  input  logic       rd_en,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       ft_wave,
  output logic       irq_ft_n,
  output logic       rst_out_n
);
  wd_cfg_t          cfg;
  logic             flag, ft_on, expire, restart, pulse_on, pin_owned;
  logic [CNT_W-1:0] cnt;

  assign restart = sel_wd && (rd_en || wr_en);

  wdog_regs u_regs (
    .clk(clk), .rst_n(rst_n), .sel_wd(sel_wd), .sel_st(sel_st),
    .rd_en(rd_en), .wr_en(wr_en), .wdata(wdata), .expire(expire),
    .cfg(cfg), .flag(flag), .ft_on(ft_on), .rdata(rdata)
  );

  wdog_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .restart(restart),
    .mult(cfg.mult), .res(cfg.res), .expire(expire), .cnt(cnt)
  );

  wdog_pulse #(.PULSE_TICKS(PULSE_TICKS)) u_pulse (
    .clk(clk), .rst_n(rst_n), .tick(tick16),
    .start(expire && cfg.steer), .active(pulse_on)
  );

  // watchdog owns the shared pin when armed toward it
  assign pin_owned = (cfg.mult != '0) && !cfg.steer;

  always_comb begin
    if (flag)                    irq_ft_n = 1'b0;
    else if (ft_on && !pin_owned) irq_ft_n = ft_wave;
    else                         irq_ft_n = 1'b1;
  end

  assign rst_out_n = !pulse_on;
endmodule

// File: rtl/wdog_checker.sv
module wdog_checker
  import wdog_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             restart,
  input logic             st_rd,
  input logic             expire,
  input wd_cfg_t          cfg,
  input logic             flag,
  input logic             ft_on,
  input logic [CNT_W-1:0] cnt,
  input logic             irq_ft_n,
  input logic             rst_out_n
);
  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> cnt == '0); // R3

  AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.mult == '0) |-> !expire); // R4

  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !st_rd && !restart) |=> flag); // R5

  AST_PIN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    flag |-> !irq_ft_n); // R9

  AST_STATUS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (st_rd && !expire) |=> !flag); // R6

  AST_STEER_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && cfg.steer) |=> (cfg == '0 && !ft_on)); // R8

  AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_out_n) |-> $past(expire && cfg.steer)); // R7

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.mult != '0) |-> (cnt < terminal(cfg.mult, cfg.res))); // R2
endmodule

bind wdog_supervisor wdog_checker u_chk (
  .clk(clk), .rst_n(rst_n), .restart(restart),
  .st_rd(sel_st && rd_en), .expire(expire), .cfg(cfg), .flag(flag),
  .ft_on(ft_on), .cnt(cnt), .irq_ft_n(irq_ft_n), .rst_out_n(rst_out_n)
);

// File: tb/wdog_supervisor_test.sv
module wdog_supervisor_test;
  logic       clk = 1'b0, rst_n = 1'b0, tick16 = 1'b0;
  logic       sel_wd = 1'b0, sel_st = 1'b0, rd_en = 1'b0, wr_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       ft_wave = 1'b0;
  logic       irq_ft_n, rst_out_n;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  wdog_supervisor uut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .sel_wd(sel_wd), .sel_st(sel_st),
    .rd_en(rd_en), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
    .ft_wave(ft_wave), .irq_ft_n(irq_ft_n), .rst_out_n(rst_out_n)
  );

  // {control value, expected ticks to interrupt}
  localparam int NV = 6;
  localparam logic [18:0] VEC [NV] = '{
    {8'h04, 11'd1},   // m1 r00
    {8'h05, 11'd4},   // m1 r01
    {8'h0E, 11'd48},  // m3 r10
    {8'h07, 11'd64},  // m1 r11
    {8'h7C, 11'd31},  // m31 r00
    {8'h09, 11'd8}    // m2 r01
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk) tick16 = 1'b1;
    @(negedge clk) tick16 = 1'b0;
  endtask

  task automatic wr_reg(input bit st, input logic [7:0] d);
    @(negedge clk) begin sel_wd = !st; sel_st = st; wr_en = 1'b1; wdata = d; end
    @(negedge clk) begin sel_wd = 1'b0; sel_st = 1'b0; wr_en = 1'b0; end
  endtask

  task automatic rd_reg(input bit st, output logic [7:0] d);
    @(negedge clk) begin sel_wd = !st; sel_st = st; rd_en = 1'b1; end
    #1 d = rdata;
    @(negedge clk) begin sel_wd = 1'b0; sel_st = 1'b0; rd_en = 1'b0; end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int k;
    bit bad;
    repeat (3) @(negedge clk);
    // R10 reset state
    check(irq_ft_n && rst_out_n, "R10 outputs", {irq_ft_n, rst_out_n}, 3);
    rst_n = 1'b1;
    rd_reg(1'b0, d); check(d == 8'h00, "R10 ctrl", d, 0);
    rd_reg(1'b1, d); check(d == 8'h00, "R10 status", d, 0);

    // R2 table walk
    for (int i = 0; i < NV; i++) begin
      wr_reg(1'b0, VEC[i][18:11]);
      rd_reg(1'b0, d); check(d == VEC[i][18:11], "R1 readback", d, VEC[i][18:11]);
      k = 0;
      while (irq_ft_n && k < 3000) begin tick(); k++; end
      check(k == int'(VEC[i][10:0]), "R2 ticks to expiry", k, VEC[i][10:0]);
      rd_reg(1'b1, d); check(d == 8'h80, "R6 status flag", d, 8'h80);
      check(irq_ft_n == 1'b1, "R5 released by status read", irq_ft_n, 1);
      rd_reg(1'b1, d); check(d == 8'h00, "R6 flag cleared", d, 0);
      wr_reg(1'b0, 8'h00);
    end

    // R4 multiplier 0 with other bits set
    wr_reg(1'b0, 8'h83);
    bad = 1'b0;
    for (int j = 0; j < 100; j++) begin
      tick();
      if (!irq_ft_n || !rst_out_n) bad = 1'b1;
    end
    check(!bad, "R4 no timeout when multiplier 0", bad, 0);
    wr_reg(1'b0, 8'h00);

    // R3 restart on read
    wr_reg(1'b0, 8'h08);
    tick();
    rd_reg(1'b0, d);
    tick(); check(irq_ft_n == 1'b1, "R3 restart delays expiry", irq_ft_n, 1);
    tick(); check(irq_ft_n == 1'b0, "R5 interrupt asserted", irq_ft_n, 0);
    wr_reg(1'b1, 8'h00);
    check(irq_ft_n == 1'b0, "R6 status write keeps flag", irq_ft_n, 0);
    rd_reg(1'b0, d);
    check(irq_ft_n == 1'b1, "R5 released by control read", irq_ft_n, 1);
    wr_reg(1'b0, 8'h00);

    // R7/R8 steered reset pulse
    wr_reg(1'b1, 8'h01);
    wr_reg(1'b0, 8'h84);
    tick(); check(rst_out_n == 1'b0, "R7 pulse starts", rst_out_n, 0);
    check(irq_ft_n == 1'b1 || ft_wave == 1'b0, "R7 no flag", irq_ft_n, 1);
    rd_reg(1'b0, d); check(d == 8'h00, "R8 control cleared", d, 0);
    rd_reg(1'b1, d); check(d == 8'h00, "R8 ft cleared, R7 no flag", d, 0);
    tick(); check(rst_out_n == 1'b0, "R7 pulse holds", rst_out_n, 0);
    tick(); check(rst_out_n == 1'b1, "R7 pulse ends after 2 ticks", rst_out_n, 1);

    // R9 pin arbitration
    wr_reg(1'b1, 8'h01);
    ft_wave = 1'b0; #1 check(irq_ft_n == 1'b0, "R9 ft wave low", irq_ft_n, 0);
    ft_wave = 1'b1; #1 check(irq_ft_n == 1'b1, "R9 ft wave high", irq_ft_n, 1);
    wr_reg(1'b0, 8'h7C);
    ft_wave = 1'b0; #1 check(irq_ft_n == 1'b1, "R9 watchdog owns pin", irq_ft_n, 1);
    wr_reg(1'b0, 8'h00);
    #1 check(irq_ft_n == 1'b0, "R9 ft back when disarmed", irq_ft_n, 0);
    wr_reg(1'b1, 8'h00);
    #1 check(irq_ft_n == 1'b1, "R9 idle high", irq_ft_n, 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule